// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host that sees a 64-bit memory-mapped register window reach a separate 32-bit register bus without mapping that bus directly. The host packs a command, a target address and write data into one 64-bit control word. The bridge turns that word into exactly one read or write on the downstream bus. The host then polls a 64-bit status word until its completion flag is set. For a read, the returned data sits in the low half of that status word.

A third, read-only host word describes the serial controller attached downstream. It reports the bit order, word width, chip-select count, clock polarity, clock phase and a peripheral identifier. All of these fields are build-time parameters.

Downstream registers are 32 bits wide on a 4-byte stride. The bridge therefore drives a word index, not a byte address. Only one access can be outstanding. Commands that arrive while one is in flight are dropped.

Top module: `regbridge_top`

## Requirements
- R1: After reset the status word reads 0 (completion flag low, read data 0), `ds_req` is low, and `host_rdata` is 0.
- R2: A host read returns its data in the cycle after `host_rd_en`. Offset 0x8 returns the parameter word: bit 1 is bit order (1 = LSB first), bits 7:2 the word width, bits 13:8 the chip-select count, bit 14 clock polarity, bit 15 clock phase, bits 47:32 the peripheral identifier, and all other bits 0. Any offset other than 0x8 and 0x18 returns 0, including the control offset 0x10.
- R3: A host write to offset 0x10 launches an access when no access is pending and bits 63:62 hold command 1 (read) or 2 (write). In the cycle after the write, `ds_req` is high and the completion flag is low. `ds_we` is 1 for write and 0 for read, `ds_wdata` carries bits 31:0, and `ds_addr` carries the byte address in bits 44:32 shifted right by two, so bits 33:32 are dropped.
- R4: `ds_req` stays high with stable `ds_we`, `ds_addr` and `ds_wdata` until a cycle in which `ds_ack` is high, and it is low in the following cycle. Each launched command makes exactly one acknowledged request.
- R5: The status word at offset 0x18 carries read data in bits 31:0 and the completion flag in bit 32; bits 63:33 are 0. The flag is set in the cycle after the acknowledge.
- R6: On the acknowledge of a read, `ds_rdata` is captured into the status read data. That value holds until the next read completes, and completed writes do not change it.
- R7: A control write with command 0 (no operation) or 3 (reserved) makes no downstream request and leaves the status word unchanged.
- R8: A control write that arrives while an access is pending is dropped. The pending access completes with its original address and data, and no second request follows.
- R9: For a read command the data field is ignored: `ds_we` stays low and no downstream register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, valid the cycle after the read strobe |
| ds_req | output | 1 | Downstream access request, held until acknowledged |
| ds_we | output | 1 | Downstream write (1) or read (0) |
| ds_addr | output | 11 | Downstream 32-bit word index |
| ds_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream acknowledge, one cycle |
| ds_rdata | input | 32 | Downstream read data, valid with the acknowledge |

## Verification
A host read's result is due one cycle after the read strobe. A launched command raises `ds_req` one cycle after the control write, and the completion flag rises one cycle after the acknowledge. The bench drives the host strobes on falling edges and samples `host_rdata` at the next falling edge, one register stage later. Because of this, the first status poll after any legal command must show the flag low, whatever the downstream latency. The downstream model acknowledges after a random or forced delay of 0 to 6 cycles. The bench checks that the request is stable while it waits and low at the falling edge after the acknowledge.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

    localparam int HOST_DW   = 64;
    localparam int DS_DW     = 32;
    localparam int CTRL_AW   = 13;
    localparam int DS_AW     = CTRL_AW - 2;
    localparam int CTRL_RSVD = HOST_DW - 2 - CTRL_AW - DS_DW;
    localparam int STAT_RSVD = HOST_DW - 1 - DS_DW;

    localparam logic [7:0] OFS_PARAM = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h18;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PARAM,
        SEL_CTRL,
        SEL_STAT
    } sel_e;

    typedef struct packed {
        cmd_e                 cmd;
        logic [CTRL_RSVD-1:0] rsvd;
        logic [CTRL_AW-1:0]   addr;
        logic [DS_DW-1:0]     data;
    } ctrl_word_t;

    typedef struct packed {
        logic [STAT_RSVD-1:0] rsvd;
        logic                 done;
        logic [DS_DW-1:0]     rdata;
    } stat_word_t;

    typedef struct packed {
        logic             we;
        logic [DS_AW-1:0] waddr;
        logic [DS_DW-1:0] wdata;
    } ds_op_t;

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

    function automatic logic [HOST_DW-1:0] pack_param(
        input logic       lsb_first,
        input logic [5:0] width,
        input logic [5:0] ncs,
        input logic       cpol,
        input logic       cpha,
        input logic [15:0] pid
    );
        logic [HOST_DW-1:0] w;
        w        = '0;
        w[1]     = lsb_first;
        w[7:2]   = width;
        w[13:8]  = ncs;
        w[14]    = cpol;
        w[15]    = cpha;
        w[47:32] = pid;
        return w;
    endfunction

endpackage

// File: rtl/rb_param_word.sv
module rb_param_word
    import regbridge_pkg::*;
#(
    parameter bit       SHIFT_LSB = 1'b0,
    parameter int       XFER_BITS = 32,
    parameter int       CS_COUNT  = 1,
    parameter bit       CPOL      = 1'b0,
    parameter bit       CPHA      = 1'b0,
    parameter bit [15:0] PERIPH_ID = 16'h0000
) (
    output logic [HOST_DW-1:0] word
);
    localparam logic [5:0] WIDTH_F = XFER_BITS[5:0];
    localparam logic [5:0] NCS_F   = CS_COUNT[5:0];

    assign word = pack_param(SHIFT_LSB, WIDTH_F, NCS_F, CPOL, CPHA, PERIPH_ID);
endmodule

// File: rtl/rb_host_decode.sv
module rb_host_decode
    import regbridge_pkg::*;
#(
    parameter int HOST_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] param_word,
    input  stat_word_t         stat_word,
    output logic               ctrl_wr,
    output logic [HOST_DW-1:0] rdata
);
    localparam int PAD = (HOST_AW > 8) ? HOST_AW - 8 : 0;

    sel_e sel;
    logic [HOST_AW+7:0] addr_ext;

    assign addr_ext = {8'h00, addr};

    always_comb begin
        if (addr_ext == {{PAD{1'b0}}, OFS_PARAM, {(HOST_AW + 8 - PAD - 8){1'b0}}} >> (HOST_AW + 8 - PAD - 8))
            sel = SEL_PARAM;
        else if (addr_ext == {{(HOST_AW){1'b0}}, OFS_CTRL})
            sel = SEL_CTRL;
        else if (addr_ext == {{(HOST_AW){1'b0}}, OFS_STAT})
            sel = SEL_STAT;
        else
            sel = SEL_NONE;
    end

    assign ctrl_wr = wr_en && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_PARAM: rdata <= param_word;
                SEL_STAT:  rdata <= stat_word;
                default:   rdata <= '0;
            endcase
        end
    end

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (sel == SEL_NONE || sel == SEL_CTRL)) |=> (rdata == '0));

    assert_stat_layout_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_STAT) |=> (rdata[HOST_DW-1:DS_DW+1] == '0));
endmodule

// File: rtl/rb_cmd_engine.sv
module rb_cmd_engine
    import regbridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic [HOST_DW-1:0] ctrl_data,
    input  logic               ds_ack,
    input  logic [DS_DW-1:0]   ds_rdata,
    output logic               ds_req,
    output logic               ds_we,
    output logic [DS_AW-1:0]   ds_addr,
    output logic [DS_DW-1:0]   ds_wdata,
    output stat_word_t         stat_word
);
    ctrl_word_t       cw;
    ds_op_t           op_q;
    logic             pend_q;
    logic             done_q;
    logic [DS_DW-1:0] rd_q;
    logic             launch;
    logic             finish;
    logic             unused_bits;

    assign cw          = ctrl_word_t'(ctrl_data);
    assign unused_bits = ^{cw.rsvd, cw.addr[1:0]};
    assign launch      = ctrl_wr && !pend_q && is_access(cw.cmd);
    assign finish      = pend_q && ds_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= '0;
            op_q   <= '0;
        end else if (launch) begin
            pend_q     <= 1'b1;
            done_q     <= 1'b0;
            op_q.we    <= (cw.cmd == CMD_WRITE);
            op_q.waddr <= cw.addr[CTRL_AW-1:2];
            op_q.wdata <= cw.data;
        end else if (finish) begin
            pend_q <= 1'b0;
            done_q <= 1'b1;
            if (!op_q.we)
                rd_q <= ds_rdata;
        end
    end

    assign ds_req   = pend_q;
    assign ds_we    = op_q.we;
    assign ds_addr  = op_q.waddr;
    assign ds_wdata = op_q.wdata;

    always_comb begin
        stat_word       = '0;
        stat_word.done  = done_q;
        stat_word.rdata = rd_q;
    end

    assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
        launch |=> (ds_req && !stat_word.done));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ds_req && !ds_ack) |=> (ds_req && $stable(ds_addr) && $stable(ds_wdata) && $stable(ds_we)));

    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (ds_req && ds_ack) |=> !ds_req);

    assert_done_set_R5: assert property (@(posedge clk) disable iff (rst)
        (ds_req && ds_ack) |=> stat_word.done);

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(ds_req && ds_ack && !ds_we) |=> $stable(stat_word.rdata));

    assert_nop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ds_req && !is_access(cw.cmd)) |=> (!ds_req && $stable(stat_word)));

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ds_req && !ds_ack) |=> (ds_req && $stable(ds_addr) && $stable(ds_we)));

    assert_read_no_we_R9: assert property (@(posedge clk) disable iff (rst)
        (launch && cw.cmd == CMD_READ) |=> !ds_we);
endmodule

// File: rtl/regbridge_top.sv
module regbridge_top
    import regbridge_pkg::*;
#(
    parameter int        HOST_AW   = 8,
    parameter bit        SHIFT_LSB = 1'b0,
    parameter int        XFER_BITS = 32,
    parameter int        CS_COUNT  = 1,
    parameter bit        CPOL      = 1'b0,
    parameter bit        CPHA      = 1'b0,
    parameter bit [15:0] PERIPH_ID = 16'h0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               ds_req,
    output logic               ds_we,
    output logic [DS_AW-1:0]   ds_addr,
    output logic [DS_DW-1:0]   ds_wdata,
    input  logic               ds_ack,
    input  logic [DS_DW-1:0]   ds_rdata
);
    logic [HOST_DW-1:0] param_word;
    stat_word_t         stat_word;
    logic               ctrl_wr;

    rb_param_word #(
        .SHIFT_LSB (SHIFT_LSB),
        .XFER_BITS (XFER_BITS),
        .CS_COUNT  (CS_COUNT),
        .CPOL      (CPOL),
        .CPHA      (CPHA),
        .PERIPH_ID (PERIPH_ID)
    ) u_param (
        .word (param_word)
    );

    rb_host_decode #(
        .HOST_AW (HOST_AW)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (host_wr_en),
        .rd_en      (host_rd_en),
        .addr       (host_addr),
        .param_word (param_word),
        .stat_word  (stat_word),
        .ctrl_wr    (ctrl_wr),
        .rdata      (host_rdata)
    );

    rb_cmd_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (host_wdata),
        .ds_ack    (ds_ack),
        .ds_rdata  (ds_rdata),
        .ds_req    (ds_req),
        .ds_we     (ds_we),
        .ds_addr   (ds_addr),
        .ds_wdata  (ds_wdata),
        .stat_word (stat_word)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ds_req && host_rdata == '0));
endmodule

// File: tb/regbridge_top_tb_top.sv
module regbridge_top_tb_top;
    localparam int          AW    = 8;
    localparam bit          P_LSB = 1'b1;
    localparam int          P_W   = 32;
    localparam int          P_CS  = 1;
    localparam bit          P_POL = 1'b0;
    localparam bit          P_PHA = 1'b1;
    localparam logic [15:0] P_ID  = 16'h5A3C;
    localparam int          NW    = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        ds_req, ds_we;
    logic [10:0] ds_addr;
    logic [31:0] ds_wdata;
    logic        ds_ack = 1'b0;
    logic [31:0] ds_rdata = '0;

    always #4 clk = ~clk;

    regbridge_top #(
        .HOST_AW(AW), .SHIFT_LSB(P_LSB), .XFER_BITS(P_W), .CS_COUNT(P_CS),
        .CPOL(P_POL), .CPHA(P_PHA), .PERIPH_ID(P_ID)
    ) dut_i (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_ack(ds_ack), .ds_rdata(ds_rdata)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    logic [31:0] dmem [NW];
    logic [31:0] ref_mem [NW];

    int          force_dly = -1;
    int          dly = 0;
    bit          seen = 0;
    bit          ack_prev = 0;
    int unsigned ack_cnt = 0;
    logic [10:0] seen_addr;
    logic [31:0] seen_wdata;
    logic        seen_we;

    function automatic logic [31:0] init_word(input int i);
        return (32'(i) * 32'h01010101) ^ 32'hA5A5_0F0F;
    endfunction

    function automatic logic [63:0] exp_param();
        logic [63:0] w = '0;
        w[1]     = P_LSB;
        w[7:2]   = 6'(P_W);
        w[13:8]  = 6'(P_CS);
        w[14]    = P_POL;
        w[15]    = P_PHA;
        w[47:32] = P_ID;
        return w;
    endfunction

    function automatic logic [63:0] mk_ctrl(input logic [1:0] c, input logic [12:0] a, input logic [31:0] d);
        return {c, 17'h0, a, d};
    endfunction

    function automatic logic [63:0] mk_stat(input logic v, input logic [31:0] d);
        return {31'h0, v, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // downstream model: acknowledges after a delay, checks request behaviour
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_prev) begin
                check(ds_req == 1'b0, "R4 req low after ack", 64'(ds_req), 64'd0);
                ack_prev = 0;
            end
            if (ds_ack) begin
                ds_ack = 1'b0;
                ack_prev = 1;
            end else if (ds_req) begin
                if (!seen) begin
                    seen = 1;
                    dly = (force_dly >= 0) ? force_dly : int'($urandom % 4);
                    seen_addr = ds_addr;
                    seen_wdata = ds_wdata;
                    seen_we = ds_we;
                end else if (ds_addr != seen_addr || ds_wdata != seen_wdata || ds_we != seen_we) begin
                    check(0, "R4 request stable", {ds_we, ds_addr, ds_wdata}, {seen_we, seen_addr, seen_wdata});
                end
                if (dly == 0) begin
                    ds_ack = 1'b1;
                    seen = 0;
                    ack_cnt++;
                    if (ds_we) dmem[ds_addr] = ds_wdata;
                    else ds_rdata = dmem[ds_addr];
                end else begin
                    dly--;
                end
            end
        end
    end

    task automatic host_write(input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, output logic [63:0] d);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic poll_done(output logic [63:0] st, output int polls);
        polls = 0;
        st = '0;
        while (polls < 40 && !st[32]) begin
            host_read(8'h18, st);
            polls++;
        end
    endtask

    // issue a legal command and wait for completion
    task automatic run_cmd(input logic [1:0] c, input logic [12:0] a, input logic [31:0] d,
                           input string req, output logic [63:0] st);
        logic [63:0] first;
        int polls;
        host_write(8'h10, mk_ctrl(c, a, d));
        host_read(8'h18, first);
        check(first[32] == 1'b0, "R3 flag cleared by launch", first, {first[63:33], 1'b0, first[31:0]});
        poll_done(st, polls);
        check(st[32] == 1'b1, req, st, {st[63:33], 1'b1, st[31:0]});
    endtask

    logic [31:0] exp_rd = '0;

    initial begin
        logic [63:0] st, v;
        int unsigned acks0;
        for (int i = 0; i < NW; i++) begin
            dmem[i] = init_word(i);
            ref_mem[i] = init_word(i);
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(host_rdata == '0, "R1 host_rdata after reset", host_rdata, 64'd0);
        check(ds_req == 1'b0, "R1 ds_req after reset", 64'(ds_req), 64'd0);
        host_read(8'h18, v);
        check(v == 64'd0, "R1 status after reset", v, 64'd0);

        // R2: parameter word and unmapped offsets
        host_read(8'h08, v);
        check(v == exp_param(), "R2 parameter word", v, exp_param());
        host_read(8'h10, v);
        check(v == 64'd0, "R2 control offset reads zero", v, 64'd0);
        host_read(8'h20, v);
        check(v == 64'd0, "R2 unmapped offset reads zero", v, 64'd0);

        // R3/R5/R6: directed write then read of the same word, low address bits dropped
        run_cmd(2'd2, 13'h0105, 32'hDEAD_BEEF, "R5 write completes", st);
        ref_mem[13'h0105 >> 2] = 32'hDEAD_BEEF;
        check(seen_addr == 11'(13'h0105 >> 2) && seen_we && seen_wdata == 32'hDEAD_BEEF,
              "R3 write fields on bus", {seen_we, seen_addr, seen_wdata}, {1'b1, 11'h041, 32'hDEAD_BEEF});
        check(st == mk_stat(1'b1, exp_rd), "R6 write leaves read data", st, mk_stat(1'b1, exp_rd));
        acks0 = ack_cnt;
        run_cmd(2'd1, 13'h0104, 32'h1234_5678, "R5 read completes", st);
        exp_rd = 32'hDEAD_BEEF;
        check(st == mk_stat(1'b1, exp_rd), "R6 read data in status", st, mk_stat(1'b1, exp_rd));
        check(seen_we == 1'b0, "R9 read has ds_we low", 64'(seen_we), 64'd0);
        check(ack_cnt == acks0 + 1, "R4 one request per command", ack_cnt, acks0 + 1);
        check(dmem[13'h0104 >> 2] == 32'hDEAD_BEEF, "R9 read data field not written", dmem[13'h0104 >> 2], 32'hDEAD_BEEF);

        // R7: no-op and reserved commands
        acks0 = ack_cnt;
        host_write(8'h10, mk_ctrl(2'd0, 13'h0010, 32'h1111_1111));
        repeat (3) @(negedge clk);
        host_read(8'h18, v);
        check(v == mk_stat(1'b1, exp_rd), "R7 nop leaves status", v, mk_stat(1'b1, exp_rd));
        host_write(8'h10, mk_ctrl(2'd3, 13'h0020, 32'h2222_2222));
        repeat (3) @(negedge clk);
        host_read(8'h18, v);
        check(v == mk_stat(1'b1, exp_rd), "R7 reserved leaves status", v, mk_stat(1'b1, exp_rd));
        check(ack_cnt == acks0, "R7 no downstream request", ack_cnt, acks0);

        // R8: command during a pending access is dropped
        force_dly = 6;
        acks0 = ack_cnt;
        host_write(8'h10, mk_ctrl(2'd2, 13'h0040, 32'hAAAA_0001));
        host_write(8'h10, mk_ctrl(2'd2, 13'h0080, 32'hBBBB_0002));
        ref_mem[13'h0040 >> 2] = 32'hAAAA_0001;
        poll_done(st, dly);
        repeat (4) @(negedge clk);
        check(ack_cnt == acks0 + 1, "R8 second command dropped", ack_cnt, acks0 + 1);
        check(seen_addr == 11'h010 && seen_wdata == 32'hAAAA_0001, "R8 first command kept",
              {seen_addr, seen_wdata}, {11'h010, 32'hAAAA_0001});
        force_dly = -1;
        run_cmd(2'd1, 13'h0080, 32'h0, "R8 readback completes", st);
        exp_rd = ref_mem[13'h0080 >> 2];
        check(st == mk_stat(1'b1, exp_rd), "R8 dropped target unchanged", st, mk_stat(1'b1, exp_rd));

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  c = 2'($urandom % 4);
            logic [12:0] a = 13'(($urandom % 16) * 4 + ($urandom % 4));
            logic [31:0] d = $urandom;
            if (c == 2'd1 || c == 2'd2) begin
                run_cmd(c, a, d, "R5 random completion", st);
                if (c == 2'd2) ref_mem[a >> 2] = d;
                else exp_rd = ref_mem[a >> 2];
                check(st == mk_stat(1'b1, exp_rd), (c == 2'd2) ? "R6 random write status" : "R3 random read data",
                      st, mk_stat(1'b1, exp_rd));
            end else begin
                host_write(8'h10, mk_ctrl(c, a, d));
                host_read(8'h18, v);
                check(v == mk_stat(1'b1, exp_rd), "R7 random nop status", v, mk_stat(1'b1, exp_rd));
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule